// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block sweeps a parallel RGB panel. From porch, sync-width and resolution settings it produces horizontal sync, vertical sync, a data-enable strobe and the column and row of the pixel being shown. Each setting is given as its count minus one. A programmable divider derives a pixel-rate enable from the source clock. The divider can be bypassed so that every source clock carries one pixel.

Each line runs sync, then back porch, then the visible pixels, then front porch. Each frame follows the same order over lines. A scan enable starts the sweep at the first pixel of a frame. When the enable is dropped, the sweep finishes the frame in progress and then parks at zero. The start of every frame can raise a one-clock interrupt pulse and a sticky pending flag. Software clears the flag by writing one to it. Each sync output has its own inversion bit.

Top module: `lcd_timing_gen`

## Requirements
- R1: While rst_ni is low, de_o, frame_irq_o and irq_pend_o are 0, x_o and y_o are 0, and each sync output equals its inversion bit.
- R2: When scanning, a line lasts (h_sync_m1+1)+(h_back_m1+1)+(h_act_m1+1)+(h_front_m1+1) pixel periods. A frame lasts the matching vertical sum of lines.
- R3: A line starts with sync, then back porch, then active pixels, then front porch. Frames use the same order over lines. Sync is active for h_sync_m1+1 pixels of every line and for v_sync_m1+1 whole lines per frame. The first active pixel comes ((v_sync_m1+v_back_m1+2)*line_length + h_sync_m1+h_back_m1+2) pixel periods after frame start.
- R4: de_o is 1 only when the pixel lies in the active columns of an active line. Per frame this gives (h_act_m1+1)*(v_act_m1+1) pixel periods.
- R5: While de_o is 1, x_o and y_o hold the zero-based column and row inside the active area. The first active pixel reads 0,0 and the last reads h_act_m1,v_act_m1. While de_o is 0, both read 0.
- R6: With div_en_i=1, pix_ce_o is high for one clock in every div_m1_i+1 clocks (range 1 to 256). With div_en_i=0, pix_ce_o is high every clock and div_m1_i has no effect. Each pixel lasts exactly one pixel-enable period.
- R7: Clearing scan_en_i lets the frame in progress finish. After that, de_o stays 0, x_o and y_o stay 0 and no frame interrupt is raised. Setting scan_en_i again starts a new frame within one frame time.
- R8: hsync_o and vsync_o are the active-high sync levels XORed with h_inv_i and v_inv_i. When idle, each sync output equals its inversion bit.
- R9: frame_irq_o pulses for one clock in the clock where vsync becomes active. This happens only when irq_en_i=1 and irq_sel_i=1 (1 selects vsync, 0 selects none). Otherwise it stays 0.
- R10: irq_pend_o is set by a frame_irq_o pulse and cleared by irq_clr_i high for one clock. A pulse in the same clock as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | source clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| scan_en_i | input | 1 | start/stop scanning |
| div_en_i | input | 1 | 1: divide source clock, 0: 1:1 |
| div_m1_i | input | DW | divide ratio minus one |
| h_sync_m1_i | input | HW | hsync width in pixels minus one |
| h_back_m1_i | input | HW | horizontal back porch minus one |
| h_act_m1_i | input | HW | active pixels per line minus one |
| h_front_m1_i | input | HW | horizontal front porch minus one |
| v_sync_m1_i | input | VW | vsync width in lines minus one |
| v_back_m1_i | input | VW | vertical back porch minus one |
| v_act_m1_i | input | VW | active lines minus one |
| v_front_m1_i | input | VW | vertical front porch minus one |
| h_inv_i | input | 1 | invert hsync_o |
| v_inv_i | input | 1 | invert vsync_o |
| irq_en_i | input | 1 | frame interrupt enable |
| irq_sel_i | input | 1 | interrupt event: 1 vsync, 0 none |
| irq_clr_i | input | 1 | write-one-to-clear for the pending flag |
| pix_ce_o | output | 1 | pixel clock enable |
| hsync_o | output | 1 | horizontal sync |
| vsync_o | output | 1 | vertical sync |
| de_o | output | 1 | data enable |
| x_o | output | HW | active column |
| y_o | output | VW | active row |
| frame_irq_o | output | 1 | one-clock frame start pulse |
| irq_pend_o | output | 1 | sticky interrupt pending |

## Verification
A horizontal or vertical counter that wraps at the wrong count changes the distance between two frame pulses. The error shows up within one frame, and it also moves the offset of the first data-enable clock. A fault in the segment decode distorts the per-frame totals of sync and data-enable clocks and the run length of the first active line. A fault in the divider shows up as wrong spacing between pixel enables. A run flag that does not stop cleanly shows up as data enable or interrupts in the two frame times after scanning is dropped.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;
endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          div_en_i,
  input  logic [DW-1:0] div_m1_i,
  output logic          pix_ce_o
);
  logic [DW-1:0] cnt_q;
  logic          at_top;

  assign at_top   = (cnt_q >= div_m1_i);
  assign pix_ce_o = !div_en_i || at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!div_en_i || at_top)  cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  // no back-to-back enables while dividing by more than one
  assert_ce_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_en_i && $past(div_en_i) && div_m1_i != '0 && $stable(div_m1_i) && $past(pix_ce_o))
      |-> !pix_ce_o);

  // bypass gives an enable every clock
  assert_ce_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_en_i && $past(!div_en_i)) |-> (pix_ce_o && $past(pix_ce_o)));
endmodule

// File: rtl/lcd_axis_seq.sv
module lcd_axis_seq
  import lcd_timing_pkg::*;
#(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         step_i,
  input  logic [W-1:0] sync_m1_i,
  input  logic [W-1:0] back_m1_i,
  input  logic [W-1:0] act_m1_i,
  input  logic [W-1:0] front_m1_i,
  output seg_e         seg_o,
  output logic [W-1:0] pos_o,
  output logic         wrap_o
);
  localparam int TW = W + 2;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] sync_end, act_beg, act_end, last_idx;
  logic          at_last;

  always_comb begin
    sync_end = TW'(sync_m1_i) + TW'(1);
    act_beg  = sync_end + TW'(back_m1_i) + TW'(1);
    act_end  = act_beg + TW'(act_m1_i) + TW'(1);
    last_idx = act_end + TW'(front_m1_i);
  end

  assign at_last = (cnt_q >= last_idx);
  assign wrap_o  = step_i && !hold_i && at_last;

  always_comb begin
    if (cnt_q < sync_end)     seg_o = SEG_SYNC;
    else if (cnt_q < act_beg) seg_o = SEG_BACK;
    else if (cnt_q < act_end) seg_o = SEG_ACT;
    else                      seg_o = SEG_FRONT;
  end

  assign pos_o = (seg_o == SEG_ACT) ? W'(cnt_q - act_beg) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (hold_i)  cnt_q <= '0;
    else if (step_i)  cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable({sync_m1_i, back_m1_i, act_m1_i, front_m1_i}) && $past(!hold_i) && !hold_i)
      |-> (cnt_q <= last_idx));

  assert_hold_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i) |-> (cnt_q == '0));
endmodule

// File: rtl/lcd_frame_irq.sv
module lcd_frame_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vs_act_i,
  input  logic irq_en_i,
  input  logic irq_sel_i,
  input  logic irq_clr_i,
  output logic pulse_o,
  output logic pend_o
);
  logic vs_q;

  assign pulse_o = irq_en_i && irq_sel_i && vs_act_i && !vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q   <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      vs_q <= vs_act_i;
      if (pulse_o)        pend_o <= 1'b1;
      else if (irq_clr_i) pend_o <= 1'b0;
    end
  end

  assert_pulse_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  assert_pend_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> pend_o);

  assert_pend_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && irq_clr_i) |=> !pend_o);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_timing_pkg::*;
#(
  parameter int HW = 11,
  parameter int VW = 11,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scan_en_i,
  input  logic          div_en_i,
  input  logic [DW-1:0] div_m1_i,
  input  logic [HW-1:0] h_sync_m1_i,
  input  logic [HW-1:0] h_back_m1_i,
  input  logic [HW-1:0] h_act_m1_i,
  input  logic [HW-1:0] h_front_m1_i,
  input  logic [VW-1:0] v_sync_m1_i,
  input  logic [VW-1:0] v_back_m1_i,
  input  logic [VW-1:0] v_act_m1_i,
  input  logic [VW-1:0] v_front_m1_i,
  input  logic          h_inv_i,
  input  logic          v_inv_i,
  input  logic          irq_en_i,
  input  logic          irq_sel_i,
  input  logic          irq_clr_i,
  output logic          pix_ce_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [HW-1:0] x_o,
  output logic [VW-1:0] y_o,
  output logic          frame_irq_o,
  output logic          irq_pend_o
);
  logic          run_q;
  logic          h_step, h_wrap, v_wrap;
  seg_e          h_seg, v_seg;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic          hs_act, vs_act;

  lcd_pix_div #(.DW(DW)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_en_i (div_en_i),
    .div_m1_i (div_m1_i),
    .pix_ce_o (pix_ce_o)
  );

  assign h_step = pix_ce_o && run_q;

  lcd_axis_seq #(.W(HW)) u_hor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (!run_q),
    .step_i     (h_step),
    .sync_m1_i  (h_sync_m1_i),
    .back_m1_i  (h_back_m1_i),
    .act_m1_i   (h_act_m1_i),
    .front_m1_i (h_front_m1_i),
    .seg_o      (h_seg),
    .pos_o      (h_pos),
    .wrap_o     (h_wrap)
  );

  lcd_axis_seq #(.W(VW)) u_ver (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (!run_q),
    .step_i     (h_wrap),
    .sync_m1_i  (v_sync_m1_i),
    .back_m1_i  (v_back_m1_i),
    .act_m1_i   (v_act_m1_i),
    .front_m1_i (v_front_m1_i),
    .seg_o      (v_seg),
    .pos_o      (v_pos),
    .wrap_o     (v_wrap)
  );

  // start on a pixel boundary; stop only at frame end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= 1'b0;
    else if (!run_q && pix_ce_o)  run_q <= scan_en_i;
    else if (run_q && v_wrap)     run_q <= scan_en_i;
  end

  assign hs_act  = run_q && (h_seg == SEG_SYNC);
  assign vs_act  = run_q && (v_seg == SEG_SYNC);
  assign de_o    = run_q && (h_seg == SEG_ACT) && (v_seg == SEG_ACT);
  assign hsync_o = hs_act ^ h_inv_i;
  assign vsync_o = vs_act ^ v_inv_i;
  assign x_o     = de_o ? h_pos : '0;
  assign y_o     = de_o ? v_pos : '0;

  lcd_frame_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vs_act_i  (vs_act),
    .irq_en_i  (irq_en_i),
    .irq_sel_i (irq_sel_i),
    .irq_clr_i (irq_clr_i),
    .pulse_o   (frame_irq_o),
    .pend_o    (irq_pend_o)
  );

  assert_de_no_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (!hs_act && !vs_act));

  assert_irq_at_vs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_irq_o |-> (vs_act && hs_act && !de_o));

  assert_stop_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!scan_en_i) && $past(!run_q) && !scan_en_i) |-> (!run_q && !de_o && !frame_irq_o));
endmodule

// File: tb/sim_lcd_timing_gen.sv
`timescale 1ns/1ps
module sim_lcd_timing_gen;
  typedef struct packed {
    logic        sel;
    logic [7:0]  val;
    logic [10:0] hs, hb, ha, hf, vs, vb, va, vf;
    logic        ih, iv;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,   11'd1, 11'd1, 11'd3, 11'd0, 11'd0, 11'd1, 11'd2, 11'd0, 1'b0, 1'b0},
    '{1'b1, 8'd2,   11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 1'b1, 1'b0},
    '{1'b1, 8'd0,   11'd3, 11'd2, 11'd7, 11'd1, 11'd1, 11'd0, 11'd4, 11'd2, 1'b0, 1'b1},
    '{1'b0, 8'd7,   11'd0, 11'd1, 11'd5, 11'd2, 11'd2, 11'd1, 11'd1, 11'd0, 1'b1, 1'b1},
    '{1'b1, 8'd255, 11'd0, 11'd0, 11'd1, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scan_en = 1'b0, div_en = 1'b0;
  logic [7:0] div_m1 = '0;
  logic [10:0] hs = '0, hb = '0, ha = '0, hf = '0, vs = '0, vb = '0, va = '0, vf = '0;
  logic h_inv = 1'b0, v_inv = 1'b0, irq_en = 1'b0, irq_sel = 1'b0, irq_clr = 1'b0;
  logic pix_ce_o, hsync_o, vsync_o, de_o, frame_irq_o, irq_pend_o;
  logic [10:0] x_o, y_o;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  lcd_timing_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scan_en_i(scan_en), .div_en_i(div_en), .div_m1_i(div_m1),
    .h_sync_m1_i(hs), .h_back_m1_i(hb), .h_act_m1_i(ha), .h_front_m1_i(hf),
    .v_sync_m1_i(vs), .v_back_m1_i(vb), .v_act_m1_i(va), .v_front_m1_i(vf),
    .h_inv_i(h_inv), .v_inv_i(v_inv), .irq_en_i(irq_en), .irq_sel_i(irq_sel), .irq_clr_i(irq_clr),
    .pix_ce_o(pix_ce_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .x_o(x_o), .y_o(y_o), .frame_irq_o(frame_irq_o), .irq_pend_o(irq_pend_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    div_en = v.sel; div_m1 = v.val;
    hs = v.hs; hb = v.hb; ha = v.ha; hf = v.hf;
    vs = v.vs; vb = v.vb; va = v.va; vf = v.vf;
    h_inv = v.ih; v_inv = v.iv;
  endtask

  task automatic wait_irq(input int lim, output bit got);
    got = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (frame_irq_o) begin got = 1; break; end
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " de idle"}, int'(de_o), 0);
    chk({req, " xy idle"}, int'(x_o) + int'(y_o), 0);
    chk({"R8 hsync idle level"}, int'(hsync_o), int'(h_inv));
    chk({"R8 vsync idle level"}, int'(vsync_o), int'(v_inv));
  endtask

  task automatic run_vec(input vec_t v);
    int d, ht, vt, frame, xres, yres;
    int cyc, n_de, n_hs, n_vs, n_ce, gap_err, last_ce, first_de, run_len, irq_hi, bad_xy;
    int x0, y0, xmax, ymax, n_irq;
    bit got, run_open;
    d = v.sel ? int'(v.val) + 1 : 1;
    ht = int'(v.hs) + int'(v.hb) + int'(v.ha) + int'(v.hf) + 4;
    vt = int'(v.vs) + int'(v.vb) + int'(v.va) + int'(v.vf) + 4;
    xres = int'(v.ha) + 1; yres = int'(v.va) + 1;
    frame = ht * vt * d;
    @(negedge clk);
    apply(v); irq_en = 1; irq_sel = 1; scan_en = 1;
    wait_irq(frame + 2 * d + 8, got);
    chk("R7 scan start raises frame pulse", int'(got), 1);
    chk("R3 vsync active at frame start", int'(vsync_o ^ v.iv), 1);
    chk("R3 hsync active at frame start", int'(hsync_o ^ v.ih), 1);
    cyc = 0; n_de = 0; n_hs = 0; n_vs = 0; n_ce = 0; gap_err = 0; last_ce = -1;
    first_de = -1; run_len = 0; run_open = 0; irq_hi = 0; bad_xy = 0;
    x0 = -1; y0 = -1; xmax = 0; ymax = 0;
    for (int g = 0; g < 2 * frame + 8; g++) begin
      if (de_o) begin
        n_de++;
        if (first_de < 0) begin first_de = cyc; x0 = int'(x_o); y0 = int'(y_o); run_open = 1; end
        if (run_open) run_len++;
        if (int'(x_o) > xmax) xmax = int'(x_o);
        if (int'(y_o) > ymax) ymax = int'(y_o);
      end else begin
        if (first_de >= 0) run_open = 0;
        if (x_o != 0 || y_o != 0) bad_xy++;
      end
      if (hsync_o ^ v.ih) n_hs++;
      if (vsync_o ^ v.iv) n_vs++;
      if (frame_irq_o) irq_hi++;
      if (pix_ce_o) begin
        n_ce++;
        if (last_ce >= 0 && cyc - last_ce != d) gap_err++;
        last_ce = cyc;
      end
      @(negedge clk);
      cyc++;
      if (frame_irq_o) break;
    end
    chk("R2 frame length in clocks", cyc, frame);
    chk("R6 pixel enables per frame", n_ce, ht * vt);
    chk("R6 pixel enable spacing errors", gap_err, 0);
    chk("R4 data enable clocks per frame", n_de, xres * yres * d);
    chk("R3 hsync clocks per frame", n_hs, (int'(v.hs) + 1) * vt * d);
    chk("R3 vsync clocks per frame", n_vs, (int'(v.vs) + 1) * ht * d);
    chk("R3 first active pixel offset",
        first_de, ((int'(v.vs) + int'(v.vb) + 2) * ht + int'(v.hs) + int'(v.hb) + 2) * d);
    chk("R3 first active run length", run_len, xres * d);
    chk("R5 first pixel column", x0, 0);
    chk("R5 first pixel row", y0, 0);
    chk("R5 last column", xmax, xres - 1);
    chk("R5 last row", ymax, yres - 1);
    chk("R5 coordinates zero outside active", bad_xy, 0);
    chk("R9 pulse width one clock", irq_hi, 1);
    scan_en = 0;
    n_irq = 0; n_de = 0;
    for (int k = 0; k < 2 * frame + 2 * d + 4; k++) begin
      @(negedge clk);
      if (frame_irq_o) n_irq++;
    end
    chk("R7 no frame pulse after stop", n_irq, 0);
    chk_idle("R7");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    int n_de, n_irq;
    apply(VECS[0]); scan_en = 1; irq_en = 1; irq_sel = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 de in reset", int'(de_o), 0);
    chk("R1 xy in reset", int'(x_o) + int'(y_o), 0);
    chk("R1 irq in reset", int'(frame_irq_o), 0);
    chk("R1 pending in reset", int'(irq_pend_o), 0);
    chk("R1 hsync in reset", int'(hsync_o), 0);
    chk("R1 vsync in reset", int'(vsync_o), 0);
    scan_en = 0;
    rst_ni = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R7 stop in mid-frame: the running frame completes in full
    @(negedge clk);
    apply(VECS[2]); irq_en = 1; irq_sel = 1; scan_en = 1;
    wait_irq(200, got);
    chk("R7 mid-frame test start", int'(got), 1);
    n_de = 0; n_irq = 0;
    for (int c = 0; c < 3 * 187; c++) begin
      if (de_o) n_de++;
      if (c > 0 && frame_irq_o) n_irq++;
      if (c == 90) scan_en = 0;
      @(negedge clk);
    end
    chk("R7 frame completes after stop", n_de, 40);
    chk("R7 no new frame after stop", n_irq, 0);
    chk_idle("R7");
    scan_en = 1;
    wait_irq(187 + 4, got);
    chk("R7 restart within a frame", int'(got), 1);
    scan_en = 0;
    repeat (3 * 187) @(negedge clk);

    // R9 event select none and enable off
    apply(VECS[0]);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk("R10 clear drops pending", int'(irq_pend_o), 0);
    irq_en = 1; irq_sel = 0; scan_en = 1;
    n_irq = 0;
    for (int c = 0; c < 3 * 63; c++) begin @(negedge clk); if (frame_irq_o) n_irq++; end
    chk("R9 select none gives no pulse", n_irq, 0);
    chk("R9 select none leaves pending clear", int'(irq_pend_o), 0);
    irq_en = 0; irq_sel = 1;
    n_irq = 0;
    for (int c = 0; c < 3 * 63; c++) begin @(negedge clk); if (frame_irq_o) n_irq++; end
    chk("R9 disabled gives no pulse", n_irq, 0);
    chk("R9 disabled leaves pending clear", int'(irq_pend_o), 0);

    // R10 pending set, set-wins, clear
    irq_en = 1;
    wait_irq(63 + 4, got);
    chk("R9 enabled pulse seen", int'(got), 1);
    @(negedge clk);
    chk("R10 pulse sets pending", int'(irq_pend_o), 1);
    wait_irq(63 + 4, got);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    chk("R10 set wins over clear", int'(irq_pend_o), 1);
    repeat (5) @(negedge clk);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    chk("R10 clear in quiet clock", int'(irq_pend_o), 0);
    scan_en = 0;
    repeat (2 * 63) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule